// File: doc/BRIEF.md
# Burst Memory Access Sequencer

The sequencer moves one 16-byte line between the chip and an external memory whose data bus is either 8 or 16 bits wide. A request carries a line address, a direction and, for writes, the 128-bit line. The sequencer splits the line into bus beats and drives chip select, an access strobe, the byte address and the write lanes for each beat. On reads it assembles the returned lanes into a 128-bit result.

Two settings in a small configuration word control how the beats are grouped and spaced. A split flag selects either one continuous burst or four short bursts with chip select released between them. A two-bit wait code sets the number of idle strobe cycles placed ahead of every beat after the first within a burst. The settings and the bus width are captured when a request is accepted, so software can change them at any time.

Top module: `burst_seq`

## Requirements
- R1: The configuration word holds the split flag at bit 20 and the wait code at bits 17:16. Both reset to 0. Every other bit reads back as 0 whatever is written.
- R2: With the split flag clear on a 16-bit bus (`bus16_i`=1), the line is moved as 8 strobed beats in one burst, with chip select held high from the first beat to the last.
- R3: With the split flag clear on an 8-bit bus (`bus16_i`=0), the line is moved as 16 strobed beats in one burst.
- R4: With the split flag set on a 16-bit bus, the line is moved as four bursts of 2 beats. Chip select is low for exactly one cycle between two bursts, and the next burst's first strobe follows that cycle.
- R5: With the split flag set on an 8-bit bus, the line is moved as four bursts of 4 beats, with the same one-cycle release between bursts.
- R6: Wait code n (00, 01, 10, 11 giving n = 0, 1, 2, 3) places n cycles with chip select high and strobe low before the second and each later beat of a burst. No wait cycles come before the first beat of any burst, and the first strobe comes in the cycle after acceptance.
- R7: The first beat uses the request address with its 4 low bits forced to 0. The address grows by 2 (16-bit bus) or 1 (8-bit bus) on every beat, including across bursts, and stays unchanged during wait cycles.
- R8: Read data is packed little-endian. The byte from line offset i lands in `rdata_o[8i+7:8i]`. On a 16-bit bus, lane [7:0] carries the even address. On an 8-bit bus, lane [15:8] is ignored.
- R9: On writes, `mem_we_o` is high with chip select. A 16-bit beat at offset i drives line byte i on [7:0] and byte i+1 on [15:8]. An 8-bit beat drives byte i on [7:0] and 0 on [15:8].
- R10: `done_o` is a one-cycle pulse in the cycle right after the final strobe. `busy_o` is high from the cycle after acceptance through the done cycle and low in the cycle after it.
- R11: A request raised while `busy_o` is high is ignored and produces no beats.
- R12: A configuration write during a transfer does not change the beat grouping or the wait spacing of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration readback |
| bus16_i | input | 1 | Bus width: 1 = 16-bit, 0 = 8-bit |
| req_i | input | 1 | Transfer request, taken when idle |
| req_we_i | input | 1 | 1 = write line, 0 = read line |
| req_addr_i | input | ADDR_W | Line address (low 4 bits ignored) |
| req_wdata_i | input | 128 | Line to write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 128 | Assembled read line |
| mem_cs_o | output | 1 | Chip select |
| mem_strb_o | output | 1 | Access strobe for the current beat |
| mem_we_o | output | 1 | Write direction, valid with chip select |
| mem_addr_o | output | ADDR_W | Byte address of the current beat |
| mem_wdata_o | output | 16 | Write lanes |
| mem_rdata_i | input | 16 | Read lanes, sampled on the strobe cycle |

## Verification
The case that is hardest to reach from the ports is a request or a configuration write that arrives in the middle of a split transfer with long waits. Both must leave the beats already in flight unchanged. The stimulus first starts an 8-bit split transfer with wait code 11. Two cycles later it raises a second request to a different line and rewrites the configuration with the opposite split flag and wait code. The scoreboard then requires every remaining strobe to keep the original address sequence and the original spacing. It also flags any strobe that has no expected beat queued for it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LINE_BYTES = 16;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LANE_W     = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STRB,
    ST_WAIT,
    ST_GAP,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg #(
  parameter int WAIT_W   = 2,
  parameter int SPLIT_BIT = 20,
  parameter int WAIT_LSB  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              split_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic              split_q;
  logic [WAIT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      split_q <= 1'b0;
      wait_q  <= '0;
    end else if (we_i) begin
      split_q <= wdata_i[SPLIT_BIT];
      wait_q  <= wdata_i[WAIT_LSB +: WAIT_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[SPLIT_BIT] = split_q;
    rdata_o[WAIT_LSB +: WAIT_W] = wait_q;
  end

  assign split_o = split_q;
  assign wait_o  = wait_q;

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (split_o == $past(wdata_i[SPLIT_BIT]))); // R1
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  split_i,
  input  logic [WAIT_W-1:0]     wait_i,
  input  logic                  bus16_i,
  output logic                  accept_o,
  output logic                  cs_o,
  output logic                  strb_o,
  output logic [OFF_W-1:0]      beat_o,
  output logic                  bus16_o,
  output logic                  busy_o,
  output logic                  done_o
);
  seq_state_e        state_q;
  logic [OFF_W-1:0]  beat_q;
  logic [WAIT_W-1:0] wcnt_q, wait_q;
  logic              split_q, bus16_q;
  logic              last_all, burst_end;

  // 16-bit bus: 8 beats, split every 2; 8-bit bus: 16 beats, split every 4
  assign last_all  = bus16_q ? (beat_q == OFF_W'(LINE_BYTES/2 - 1))
                             : (beat_q == OFF_W'(LINE_BYTES - 1));
  assign burst_end = split_q && (bus16_q ? beat_q[0] : (&beat_q[1:0]));
  assign accept_o  = req_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wcnt_q  <= '0;
      wait_q  <= '0;
      split_q <= 1'b0;
      bus16_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_STRB;
          beat_q  <= '0;
          split_q <= split_i;
          wait_q  <= wait_i;
          bus16_q <= bus16_i;
        end
        ST_STRB: begin
          if (last_all) state_q <= ST_DONE;
          else begin
            beat_q <= beat_q + OFF_W'(1);
            if (burst_end) state_q <= ST_GAP;
            else if (wait_q != '0) begin
              state_q <= ST_WAIT;
              wcnt_q  <= wait_q;
            end
          end
        end
        ST_WAIT: begin
          if (wcnt_q == WAIT_W'(1)) state_q <= ST_STRB;
          else wcnt_q <= wcnt_q - WAIT_W'(1);
        end
        ST_GAP:  state_q <= ST_STRB;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o    = (state_q == ST_STRB) || (state_q == ST_WAIT);
  assign strb_o  = (state_q == ST_STRB);
  assign beat_o  = beat_q;
  assign bus16_o = bus16_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R10
  AST_DONE_AFTER_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strb_o)); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R10
  AST_FIRST_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> strb_o); // R6
  AST_GAP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cs_o && !done_o) |=> strb_o); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable({split_q, wait_q, bus16_q})); // R12
  AST_WAIT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (wait_q != '0)); // R6
endmodule

// File: rtl/burst_lanes.sv
module burst_lanes
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [LINE_W-1:0]   wline_i,
  input  logic                strb_i,
  input  logic                cs_i,
  input  logic [OFF_W-1:0]    beat_i,
  input  logic                bus16_i,
  input  logic [LANE_W-1:0]   mem_rdata_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [LANE_W-1:0]   mem_wdata_o,
  output logic [LINE_W-1:0]   rline_o
);
  logic [ADDR_W-OFF_W-1:0] base_q;
  logic [LINE_W-1:0]       wline_q, rline_q;
  logic                    we_q;
  logic [OFF_W-1:0]        off;
  int unsigned             bit_idx;

  assign off     = bus16_i ? {beat_i[OFF_W-2:0], 1'b0} : beat_i;
  assign bit_idx = 8 * int'(off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      wline_q <= '0;
      rline_q <= '0;
      we_q    <= 1'b0;
    end else if (accept_i) begin
      base_q  <= addr_i[ADDR_W-1:OFF_W];
      wline_q <= wline_i;
      we_q    <= we_i;
      rline_q <= '0;
    end else if (strb_i) begin
      rline_q[bit_idx +: 8] <= mem_rdata_i[7:0];
      if (bus16_i) rline_q[bit_idx + 8 +: 8] <= mem_rdata_i[15:8];
    end
  end

  always_comb begin
    mem_wdata_o = '0;
    mem_wdata_o[7:0] = wline_q[bit_idx +: 8];
    if (bus16_i) mem_wdata_o[15:8] = wline_q[bit_idx + 8 +: 8];
  end

  assign mem_addr_o = {base_q, off};
  assign mem_we_o   = we_q && cs_i;
  assign rline_o    = rline_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && $past(strb_i)) |->
      (mem_addr_o == $past(mem_addr_o) + (bus16_i ? ADDR_W'(2) : ADDR_W'(1)))); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !strb_i && $past(cs_i && !strb_i)) |-> $stable(mem_addr_o)); // R7
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  input  logic                bus16_i,
  input  logic                req_i,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [127:0]        req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [127:0]        rdata_o,
  output logic                mem_cs_o,
  output logic                mem_strb_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [15:0]         mem_wdata_o,
  input  logic [15:0]         mem_rdata_i
);
  logic              split, accept, bus16_q;
  logic [WAIT_W-1:0] wait_code;
  logic [OFF_W-1:0]  beat;

  burst_cfg_reg #(.WAIT_W(WAIT_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .split_o(split), .wait_o(wait_code)
  );

  burst_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_i, .split_i(split), .wait_i(wait_code), .bus16_i,
    .accept_o(accept), .cs_o(mem_cs_o), .strb_o(mem_strb_o),
    .beat_o(beat), .bus16_o(bus16_q), .busy_o, .done_o
  );

  burst_lanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk_i, .rst_ni,
    .accept_i(accept), .addr_i(req_addr_i), .we_i(req_we_i), .wline_i(req_wdata_i),
    .strb_i(mem_strb_o), .cs_i(mem_cs_o), .beat_i(beat), .bus16_i(bus16_q),
    .mem_rdata_i, .mem_we_o, .mem_addr_o, .mem_wdata_o, .rline_o(rdata_o)
  );
endmodule

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, bus16 = 1'b0, req = 1'b0, req_we = 1'b0;
  logic [31:0] cfg_wdata = '0, req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [31:0] cfg_rdata, mem_addr;
  logic busy, done, mem_cs, mem_strb, mem_we;
  logic [127:0] rdata;
  logic [15:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  burst_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .bus16_i(bus16), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .mem_cs_o(mem_cs), .mem_strb_o(mem_strb), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // memory model: upper lane carries junk on an 8-bit bus
  assign mem_rdata = bus16 ? {mem_byte(mem_addr + 32'd1), mem_byte(mem_addr)}
                           : {8'hEE, mem_byte(mem_addr)};

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [15:0] wdata;
    int          delta;
    bit          gap;
    string       tag;
  } beat_t;

  beat_t sb_q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_t = 0, last_strb_cyc = 0;
  bit saw_gap = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops one expected beat per strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_strb) begin
        if (sb_q.size() == 0) chk(0, "R11 unexpected strobe", {96'h0, mem_addr}, '0);
        else begin
          beat_t e;
          e = sb_q.pop_front();
          chk(mem_addr == e.addr, {e.tag, " R7 addr"}, {96'h0, mem_addr}, {96'h0, e.addr});
          chk((cyc - last_t) == e.delta, {e.tag, " R6 spacing"}, 128'(cyc - last_t), 128'(e.delta));
          chk(saw_gap == e.gap, {e.tag, " R4 cs release"}, 128'(saw_gap), 128'(e.gap));
          chk(mem_we == e.we, "R9 we", 128'(mem_we), 128'(e.we));
          if (e.we) chk(mem_wdata == e.wdata, "R9 wdata", 128'(mem_wdata), 128'(e.wdata));
        end
        last_t = cyc;
        last_strb_cyc = cyc;
        saw_gap = 0;
      end else if (busy && !mem_cs && !done) begin
        saw_gap = 1;
      end
    end
  end

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input bit b16, input bit split, input logic [1:0] w,
                          input logic [31:0] a, input bit we, input logic [127:0] line,
                          input bit disturb);
    logic [31:0] junk, exp_cfg, base;
    logic [127:0] exp_line;
    int bl, nb;
    string tag;
    junk = 32'hFFCE_FFFF & ~(32'h1 << 20) & ~(32'h3 << 16);
    exp_cfg = (32'(split) << 20) | (32'(w) << 16);
    cfg_write(junk | exp_cfg);
    chk(cfg_rdata == exp_cfg, "R1 readback", 128'(cfg_rdata), 128'(exp_cfg));
    bus16 = b16;
    nb = b16 ? 8 : 16;
    bl = split ? (b16 ? 2 : 4) : nb;
    tag = b16 ? (split ? "R4" : "R2") : (split ? "R5" : "R3");
    base = {a[31:4], 4'h0};
    for (int j = 0; j < nb; j++) begin
      beat_t e;
      int off;
      off = b16 ? 2 * j : j;
      e.addr = base + 32'(off);
      e.we = we;
      e.wdata = b16 ? {line[8*off+8 +: 8], line[8*off +: 8]} : {8'h00, line[8*off +: 8]};
      e.tag = tag;
      if (j == 0) begin e.delta = 1; e.gap = 0; end
      else if (j % bl == 0) begin e.delta = 2; e.gap = 1; end
      else begin e.delta = int'(w) + 1; e.gap = 0; end
      sb_q.push_back(e);
    end
    for (int i = 0; i < 16; i++) exp_line[8*i +: 8] = mem_byte(base + 32'(i));
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = line;
    last_t = cyc;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", 128'(busy), 128'd1);
    if (disturb) begin
      @(negedge clk);
      req = 1'b1; req_addr = 32'hDEAD_BEE0; req_we = ~we;
      cfg_we = 1'b1; cfg_wdata = (32'(~split) << 20) | (32'(~w) << 16);
      @(negedge clk);
      req = 1'b0; cfg_we = 1'b0;
    end
    do @(negedge clk); while (!done);
    chk(cyc == last_strb_cyc + 1, "R10 done timing", 128'(cyc), 128'(last_strb_cyc + 1));
    chk(busy == 1'b1, "R10 busy at done", 128'(busy), 128'd1);
    chk(sb_q.size() == 0, {tag, " beat count"}, 128'(sb_q.size()), 128'd0);
    @(negedge clk);
    chk(!done && !busy, "R10 release", 128'({done, busy}), 128'd0);
    if (!we) chk(rdata == exp_line, "R8 packing", rdata, exp_line);
    repeat (3) @(negedge clk);
    chk(!mem_cs, "R11 idle after done", 128'(mem_cs), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 32'h0 && !busy && !mem_cs && !done, "R1 reset state",
        128'({cfg_rdata, busy, mem_cs, done}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1 reset value", 128'(cfg_rdata), 128'd0);
    run_xfer(1, 0, 2'd0, 32'h0000_1000, 0, '0, 0);                          // R2
    run_xfer(0, 0, 2'd1, 32'h0000_2239, 0, '0, 0);                          // R3 R7
    run_xfer(1, 1, 2'd2, 32'h0000_0047, 1, 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, 0); // R4 R9
    run_xfer(0, 1, 2'd3, 32'h0000_3350, 0, '0, 1);                          // R5 R11 R12
    run_xfer(1, 0, 2'd3, 32'h0000_40A0, 1, 128'h00112233445566778899AABBCCDDEEFF, 0); // R6 R9
    run_xfer(0, 1, 2'd0, 32'h0000_5AF0, 1, 128'hFEDCBA98765432100123456789ABCDEF, 1); // R5 R12
    run_xfer(1, 1, 2'd1, 32'h0000_6010, 0, '0, 1);                          // R4 R8
    summary();
  end
endmodule